// File: doc/BRIEF.md
# Two-Stage SD Clock Divider

This block derives the SD card clock cadence from a fast base clock. It does not toggle a clock net. It emits a one-cycle clock-enable pulse, `sdclk_en`, once per divided SD clock period. The divide ratio is the product of two stages. The first stage is a power-of-two prescaler selected by an 8-bit code. The second stage is a linear divisor selected by a 4-bit code. A data-timeout counter counts those SD clock pulses. After a programmable power-of-two number of them, it raises a sticky expiry flag.

Software writes the whole configuration in one strobe: prescaler code, linear code, timeout code and three gate enables (interface, host, peripheral). The divider runs only while all three gates are set. The safe way to change settings is a fixed sequence:
1. Write the word with the gates cleared.
2. Write the new divide and timeout codes together with the gates set.

Divide and timeout codes written while the divider runs are held back until the next stop. Because of this, the pulse train never shows a shortened or stretched period. Each restart begins from cleared counters. A start-of-data strobe restarts the timeout count and clears the expiry flag.

Top module: `sd_clkgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `sdclk_en` and `tmo_expired` are 0.
- R2: With prescaler code 0x00, linear code n (0..15) gives one `sdclk_en` pulse every n+1 base cycles.
- R3: Prescaler code 0x00 divides by 1. A one-hot code k divides by 2*k. The total period is the prescaler ratio times the linear ratio. For example, 0x01 with 3 gives 8, and 0x10 with 15 gives 512.
- R4: A prescaler code with more than one bit set divides as if only its highest set bit were set. For example, 0x06 with linear 0 gives 8, and 0x81 with 0 gives 256.
- R5: `sdclk_en` is high for exactly one base cycle per period when the total ratio exceeds 1, and is high continuously when it is 1.
- R6: `cfg_gate` bit 0 is the interface enable, bit 1 the host enable and bit 2 the peripheral enable. If any of them is clear, `sdclk_en` stays low from the second cycle after the write onwards.
- R7: Divide and timeout codes written while the divider is running have no effect on the pulse period until the gates are cleared and set again.
- R8: A timeout code c below 15 sets `tmo_expired` after 2^(c+TMO_BASE_LOG2) `sdclk_en` pulses counted from a start strobe. `tmo_expired` rises in the cycle after the last counted pulse. Code 15 behaves as code 14.
- R9: `tmo_expired` stays high until the next `data_start`. That strobe clears it in the following cycle and restarts the count from zero. A pulse coincident with the strobe is not counted.
- R10: After the gates are set, the first `sdclk_en` pulse appears exactly one total period after the divider starts. This is D+1 cycles after the enabling write, where D is the total ratio, with counters cleared by the stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_prescale | input | 8 | Power-of-two prescaler code |
| cfg_divisor | input | 4 | Linear divisor code (divide by code+1) |
| cfg_timeout | input | 4 | Data-timeout exponent code |
| cfg_gate | input | 3 | Gate enables: bit 0 interface, bit 1 host, bit 2 peripheral |
| data_start | input | 1 | Start-of-data strobe, restarts timeout |
| sdclk_en | output | 1 | One-cycle SD clock enable pulse |
| tmo_expired | output | 1 | Sticky data-timeout expiry flag |

## Verification
The bench walks a table of prescaler and linear codes, including malformed prescaler codes with several bits set. For each, it measures both the first-pulse delay and the steady period. A decoder that used the lowest set bit, or that summed the stages, shows the wrong period here. A design that kept stale counters across a restart shows the wrong first delay.

Further cases cover:
- Clearing each gate bit alone, which catches a design that ANDs only some enables.
- Rewriting codes mid-run, which catches a divider that picks up new values immediately and produces an off-length period.
- Timeout boundaries at exactly the last pulse, including the clamped code 15. An off-by-one counter or a flag that is not sticky is caught there.

// File: rtl/sd_clkgen_pkg.sv
package sd_clkgen_pkg;
  localparam int SDC_PRE_W  = 8;  // prescaler code width
  localparam int SDC_LIN_W  = 4;  // linear divisor code width
  localparam int SDC_TMO_W  = 4;  // timeout code width
  localparam int SDC_GATE_N = 3;  // number of gate enables

  // gate bit positions
  localparam int GATE_IF   = 0;
  localparam int GATE_HOST = 1;
  localparam int GATE_PER  = 2;

  typedef struct packed {
    logic [SDC_PRE_W-1:0] pre;
    logic [SDC_LIN_W-1:0] lin;
    logic [SDC_TMO_W-1:0] tmo;
  } div_cfg_t;
endpackage

// File: rtl/sd_clkgen_cfg.sv
module sd_clkgen_cfg
  import sd_clkgen_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [SDC_PRE_W-1:0]    cfg_prescale,
  input  logic [SDC_LIN_W-1:0]    cfg_divisor,
  input  logic [SDC_TMO_W-1:0]    cfg_timeout,
  input  logic [SDC_GATE_N-1:0]   cfg_gate,
  output logic                    run,
  output div_cfg_t                act
);
  div_cfg_t              cfg_q;
  logic [SDC_GATE_N-1:0] gate_q;

  // Software-visible configuration word.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      gate_q <= '0;
    end else if (cfg_we) begin
      cfg_q.pre <= cfg_prescale;
      cfg_q.lin <= cfg_divisor;
      cfg_q.tmo <= cfg_timeout;
      gate_q    <= cfg_gate;
    end
  end

  // Run needs every gate. The shadow copy follows the config only while stopped.
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      act <= '0;
    end else begin
      run <= &gate_q;
      if (!run) act <= cfg_q;
    end
  end

  // R7: the active settings are frozen for as long as the divider keeps running
  assert_shadow_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(act));
endmodule

// File: rtl/sd_clkgen_div.sv
module sd_clkgen_div
  import sd_clkgen_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [SDC_PRE_W-1:0] pre_code,
  input  logic [SDC_LIN_W-1:0] lin_code,
  output logic                 sdclk_en
);
  localparam int SHIFT_W = $clog2(SDC_PRE_W + 1);
  localparam int MASK_W  = SDC_PRE_W + 1;

  // Prescale shift: 0 for code zero, otherwise 1 + index of highest set bit.
  function automatic logic [SHIFT_W-1:0] pre_shift(input logic [SDC_PRE_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    s = '0;
    for (int i = 0; i < SDC_PRE_W; i++)
      if (code[i]) s = SHIFT_W'(i + 1);
    return s;
  endfunction

  logic [SHIFT_W-1:0]   shift;
  logic [MASK_W-1:0]    pre_last;
  logic [SDC_PRE_W-1:0] pre_cnt;
  logic [SDC_LIN_W-1:0] lin_cnt;
  logic                 pre_tick;
  logic                 lin_wrap;

  always_comb begin
    shift    = pre_shift(pre_code);
    pre_last = (MASK_W'(1) << shift) - MASK_W'(1);
    pre_tick = ({1'b0, pre_cnt} == pre_last);
    lin_wrap = pre_tick && (lin_cnt == lin_code);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt  <= '0;
      lin_cnt  <= '0;
      sdclk_en <= 1'b0;
    end else begin
      pre_cnt  <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick)
        lin_cnt <= (lin_cnt == lin_code) ? '0 : lin_cnt + 1'b1;
      sdclk_en <= lin_wrap;
    end
  end

  // R6: no enable pulse once the divider is stopped
  assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sdclk_en);

  // R5: pulses are single-cycle whenever the total ratio exceeds one
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (sdclk_en && run && (shift != '0 || lin_code != '0)) |=> !sdclk_en);
endmodule

// File: rtl/sd_clkgen_tmo.sv
module sd_clkgen_tmo
  import sd_clkgen_pkg::*;
#(
  parameter int BASE_LOG2 = 13
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sd_tick,
  input  logic                 start,
  input  logic [SDC_TMO_W-1:0] code,
  output logic                 expired
);
  localparam int CODE_MAX = (1 << SDC_TMO_W) - 2;
  localparam int CNT_W    = BASE_LOG2 + CODE_MAX + 1;

  logic [SDC_TMO_W-1:0] code_eff;
  logic [CNT_W-1:0]     last;
  logic [CNT_W-1:0]     cnt;
  logic                 armed;

  always_comb begin
    code_eff = (int'(code) > CODE_MAX) ? SDC_TMO_W'(CODE_MAX) : code;
    last     = (CNT_W'(1) << (BASE_LOG2 + int'(code_eff))) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      armed   <= 1'b0;
      expired <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      armed   <= 1'b1;
      expired <= 1'b0;
    end else if (armed && sd_tick) begin
      if (cnt == last) begin
        cnt     <= '0;
        armed   <= 1'b0;
        expired <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: the expiry flag holds until a start strobe
  assert_expired_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (expired && !start) |=> expired);

  // R9: a start strobe clears the flag in the following cycle
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> !expired);

  // R8: the flag can only rise on a counted SD clock pulse
  assert_rise_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (!expired && !(armed && sd_tick)) |=> !expired);
endmodule

// File: rtl/sd_clkgen.sv
module sd_clkgen
  import sd_clkgen_pkg::*;
#(
  parameter int TMO_BASE_LOG2 = 13
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [SDC_PRE_W-1:0]  cfg_prescale,
  input  logic [SDC_LIN_W-1:0]  cfg_divisor,
  input  logic [SDC_TMO_W-1:0]  cfg_timeout,
  input  logic [SDC_GATE_N-1:0] cfg_gate,
  input  logic                  data_start,
  output logic                  sdclk_en,
  output logic                  tmo_expired
);
  logic     run;
  div_cfg_t act;

  sd_clkgen_cfg u_cfg (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_prescale (cfg_prescale),
    .cfg_divisor  (cfg_divisor),
    .cfg_timeout  (cfg_timeout),
    .cfg_gate     (cfg_gate),
    .run          (run),
    .act          (act)
  );

  sd_clkgen_div u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .pre_code (act.pre),
    .lin_code (act.lin),
    .sdclk_en (sdclk_en)
  );

  sd_clkgen_tmo #(.BASE_LOG2(TMO_BASE_LOG2)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .sd_tick (sdclk_en),
    .start   (data_start),
    .code    (act.tmo),
    .expired (tmo_expired)
  );

  // R1: outputs are quiet in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sdclk_en && !tmo_expired));
endmodule

// File: tb/sd_clkgen_test.sv
module sd_clkgen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_prescale = '0;
  logic [3:0] cfg_divisor = '0;
  logic [3:0] cfg_timeout = '0;
  logic [2:0] cfg_gate = '0;
  logic       data_start = 1'b0;
  logic       sdclk_en;
  logic       tmo_expired;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  sd_clkgen #(.TMO_BASE_LOG2(0)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_prescale(cfg_prescale),
    .cfg_divisor(cfg_divisor), .cfg_timeout(cfg_timeout), .cfg_gate(cfg_gate),
    .data_start(data_start), .sdclk_en(sdclk_en), .tmo_expired(tmo_expired)
  );

  // {prescale code, linear code, expected total ratio}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 4'd0,  12'd1},    // R2
    {8'h00, 4'd3,  12'd4},    // R2
    {8'h00, 4'd15, 12'd16},   // R2
    {8'h01, 4'd0,  12'd2},    // R3
    {8'h01, 4'd3,  12'd8},    // R3
    {8'h10, 4'd15, 12'd512},  // R3
    {8'h80, 4'd1,  12'd512},  // R3
    {8'h04, 4'd2,  12'd24},   // R3
    {8'h06, 4'd0,  12'd8},    // R4
    {8'h81, 4'd0,  12'd256},  // R4
    {8'h03, 4'd2,  12'd12},   // R4
    {8'hFF, 4'd0,  12'd256}   // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] p, input logic [3:0] l,
                    input logic [3:0] t, input logic [2:0] g);
    @(negedge clk);
    cfg_we = 1'b1; cfg_prescale = p; cfg_divisor = l; cfg_timeout = t; cfg_gate = g;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic restart(input logic [7:0] p, input logic [3:0] l, input logic [3:0] t);
    wr(p, l, t, 3'b000);
    wr(p, l, t, 3'b111);
  endtask

  // Measure first delay after an enabling write (already issued) and steady period.
  task automatic measure(input string req, input int d);
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!sdclk_en && n < 3000);
    chk({req, " first delay (R10)"}, n, d + 1);
    @(negedge clk);
    if (d > 1) chk({req, " pulse width (R5)"}, int'(sdclk_en), 0);
    n = 1;
    while (!sdclk_en && n < 3000) begin @(negedge clk); n++; end
    chk({req, " period"}, n, d);
  endtask

  task automatic strobe_start();
    @(negedge clk); data_start = 1'b1;
    @(negedge clk); data_start = 1'b0;
  endtask

  // Count pulses from the start strobe; check flag around pulse number lim.
  task automatic tmo_run(input string req, input int lim);
    int p;
    p = 0;
    strobe_start();
    while (p < lim) begin
      if (sdclk_en) p++;
      if (p < lim) begin
        if (tmo_expired) break;
        @(negedge clk);
      end
    end
    chk({req, " not expired at last pulse"}, int'(tmo_expired), 0);
    @(negedge clk);
    chk({req, " expired after last pulse"}, int'(tmo_expired), 1);
  endtask

  initial begin : watchdog
    while (cycles < 190000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 sdclk_en in reset", int'(sdclk_en), 0);
    chk("R1 tmo_expired in reset", int'(tmo_expired), 0);
    @(negedge clk); rst = 1'b0;
    chk("R1 sdclk_en after reset", int'(sdclk_en), 0);
    chk("R1 tmo_expired after reset", int'(tmo_expired), 0);

    // Table of divide settings: R2 R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:16], VEC[i][15:12], 4'd0, 3'b000);
      wr(VEC[i][23:16], VEC[i][15:12], 4'd0, 3'b111);
      measure($sformatf("R2/R3/R4 vector %0d", i), int'(VEC[i][11:0]));
    end

    // R6: each gate bit alone stops the clock
    for (int g = 0; g < 3; g++) begin
      restart(8'h00, 4'd3, 4'd0);
      repeat (10) @(negedge clk);
      wr(8'h00, 4'd3, 4'd0, 3'b111 & ~(3'b001 << g));
      n = 0;
      @(negedge clk);
      repeat (40) begin @(negedge clk); if (sdclk_en) n++; end
      chk($sformatf("R6 pulses with gate bit %0d clear", g), n, 0);
    end

    // R7: mid-run rewrite ignored, then applied after stop/start
    restart(8'h01, 4'd3, 4'd0);
    measure("R7 baseline", 8);
    wr(8'h00, 4'd0, 4'd0, 3'b111);
    n = 0;
    repeat (64) begin @(negedge clk); if (sdclk_en) n++; end
    chk("R7 pulses in 64 cycles after mid-run write", n, 8);
    restart(8'h00, 4'd0, 4'd0);
    measure("R7 after restart", 1);

    // R8: timeout lengths in SD clocks (base exponent 0 in this bench)
    restart(8'h00, 4'd1, 4'd2);
    repeat (6) @(negedge clk);
    tmo_run("R8 code 2 divide 2", 4);
    restart(8'h00, 4'd0, 4'd0);
    repeat (4) @(negedge clk);
    tmo_run("R8 code 0", 1);
    restart(8'h00, 4'd0, 4'd14);
    repeat (4) @(negedge clk);
    tmo_run("R8 code 14", 16384);
    restart(8'h00, 4'd0, 4'd15);
    repeat (4) @(negedge clk);
    tmo_run("R8 code 15 clamps to 14", 16384);

    // R9: sticky flag, clear and restart on strobe
    restart(8'h00, 4'd0, 4'd3);
    repeat (4) @(negedge clk);
    tmo_run("R9 first run", 8);
    repeat (20) @(negedge clk);
    chk("R9 flag sticky", int'(tmo_expired), 1);
    tmo_run("R9 rerun after strobe", 8);
    strobe_start();
    chk("R9 strobe clears flag", int'(tmo_expired), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule